// File: doc/BRIEF.md
# Frame-synchronised parameter register loader

This block turns a narrow byte stream into a wide set of pattern parameters. Each byte carries a tag in its top bit. A tagged byte selects one of several 7-bit slots. An untagged byte writes its low seven bits into the slot that was last selected. The slots sit in a staging copy, and the staging copy is checked against nothing while it is being built.

When the vertical sync input rises, the whole staging copy moves into the active register in one clock edge. The active register is the only output, so the downstream pattern logic sees either the complete old set or the complete new set and never a mix of the two. A host can therefore rewrite any number of slots during a frame. The new values all take effect together at the start of the next frame.

Top module: `param_shadow_loader`

## Requirements
- R1: While rst_n is low at a rising clock edge, the active register, the staging copy and the address-valid flag are cleared. Active reads zero after that edge, and data bytes arriving after reset are ignored until an address byte arrives.
- R2: A sampled byte with bit 7 equal to 1 is an address byte. Its bits 6..0 become the selected slot number.
- R3: A sampled byte with bit 7 equal to 0 is a data byte. Its bits 6..0 are written into the selected slot n of the staging copy, which occupies bits 7n+6 down to 7n. No other slot changes.
- R4: A data byte that arrives when no address byte has been sampled since reset changes nothing.
- R5: An address byte with a value of 7 or more is accepted. Data bytes that follow it change no slot.
- R6: The selected slot stays selected after a data write, so each further data byte overwrites the same slot.
- R7: A byte is sampled only at a rising clock edge where byte_vld is high. Otherwise it has no effect.
- R8: The active register takes the staging copy at the clock edge where vsync is first seen high after being low. It keeps its value at every other edge, including while vsync is held high.
- R9: When a data byte is written at the same edge as a commit, the active register receives the staging contents from before that write. The written value appears at the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_in | input | 8 | Tagged byte: bit 7 set for an address byte, clear for a data byte |
| byte_vld | input | 1 | High for each cycle in which byte_in carries a byte |
| vsync | input | 1 | Vertical sync level; a low-to-high change triggers the commit |
| params_active | output | 49 | Active parameter register, slot n in bits 7n+6..7n |

## Verification
The assertions assume that vsync and byte_in are synchronous to clk and stable around each rising edge. They also assume that reset is held for at least one edge before any byte is sent. The bench drives every input on the falling edge, which satisfies both assumptions. It opens every run with several reset cycles.

The commit assertions do not depend on how many bytes arrive in a frame. The bench therefore sends bytes both while vsync is low and while vsync is held high. It also sends one byte on the same edge as a vsync rise.

// File: rtl/psl_pkg.sv
// Package psl_pkg
// Shared constants for the tagged-byte parameter loader.
// Assumes one byte carries a tag bit on top of one full slot value.
package psl_pkg;
    parameter int unsigned BYTE_W = 8;
    localparam int unsigned SLOT_W = BYTE_W - 1;
    localparam int unsigned TAG_BIT = BYTE_W - 1;
endpackage

// File: rtl/psl_tag_decoder.sv
// Module psl_tag_decoder
// Classifies each sampled byte as an address or a data byte.
// Keeps the last slot address and whether one has been seen since reset.
// Raises a one-cycle write request for in-range data bytes.
// Assumes byte_in is valid whenever byte_vld is high.
module psl_tag_decoder
    import psl_pkg::*;
#(
    parameter int unsigned SLOT_N = 7,
    localparam int unsigned IDX_W = (SLOT_N > 1) ? $clog2(SLOT_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              byte_vld,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_slot,
    output logic [SLOT_W-1:0] wr_data
);
    localparam logic [SLOT_W-1:0] SLOT_LIM = SLOT_W'(SLOT_N);

    logic [SLOT_W-1:0] addr_q;
    logic              addr_seen_q;
    logic              is_addr;
    logic              is_data;
    logic              addr_in_range;

    // Split a sampled byte by its tag bit.
    always_comb begin
        is_addr = byte_vld &&  byte_in[TAG_BIT];
        is_data = byte_vld && !byte_in[TAG_BIT];
    end

    // Latch the slot address and remember that one has arrived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q      <= '0;
            addr_seen_q <= 1'b0;
        end else if (is_addr) begin
            addr_q      <= byte_in[SLOT_W-1:0];
            addr_seen_q <= 1'b1;
        end
    end

    // Form the write request for a data byte to a valid slot.
    always_comb begin
        addr_in_range = addr_q < SLOT_LIM;
        wr_en   = is_data && addr_seen_q && addr_in_range;
        wr_slot = IDX_W'(addr_q);
        wr_data = byte_in[SLOT_W-1:0];
    end

    AST_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_addr && addr_seen_q) |=> $stable(addr_q)) else $error("addr"); // R6

    AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        addr_seen_q |=> addr_seen_q) else $error("seen"); // R2
endmodule

// File: rtl/psl_stage_bank.sv
// Module psl_stage_bank
// Staging copy of the parameter register, built from SLOT_N slot registers.
// A write request updates exactly one slot; all other slots hold their value.
// Assumes wr_slot is below SLOT_N whenever wr_en is high.
module psl_stage_bank
    import psl_pkg::*;
#(
    parameter int unsigned SLOT_N = 7,
    localparam int unsigned IDX_W = (SLOT_N > 1) ? $clog2(SLOT_N) : 1,
    localparam int unsigned REG_W = SLOT_N * SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_slot,
    input  logic [SLOT_W-1:0] wr_data,
    output logic [REG_W-1:0]  stage
);
    logic [SLOT_N-1:0] slot_we;

    for (genvar gi = 0; gi < SLOT_N; gi++) begin : g_slot
        logic [SLOT_W-1:0] slot_q;

        // Decode the write request for this slot.
        always_comb slot_we[gi] = wr_en && (wr_slot == IDX_W'(gi));

        // Hold or load this slot's staged value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (slot_we[gi]) begin
                slot_q <= wr_data;
            end
        end

        assign stage[gi*SLOT_W +: SLOT_W] = slot_q;
    end

    AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_we)) else $error("multi"); // R3

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({{(32-IDX_W){1'b0}}, wr_slot} < SLOT_N)) else $error("range"); // R5

    AST_STAGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(stage)) else $error("idle"); // R7
endmodule

// File: rtl/psl_frame_commit.sv
// Module psl_frame_commit
// Detects the rising edge of vsync with one register and copies the staging
// copy into the active register at that edge. Holds the active register otherwise.
// Assumes vsync is already synchronous to clk.
module psl_frame_commit #(
    parameter int unsigned REG_W = 49
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync,
    input  logic [REG_W-1:0] stage,
    output logic [REG_W-1:0] active
);
    logic vs_q;
    logic vs_rise;

    // Remember the vsync level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) vs_q <= 1'b0;
        else        vs_q <= vsync;
    end

    // Flag the first cycle of a high vsync.
    always_comb vs_rise = vsync && !vs_q;

    // Load the active register only on a vsync rise.
    always_ff @(posedge clk) begin
        if (!rst_n)       active <= '0;
        else if (vs_rise) active <= stage;
    end

    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise |=> (active == $past(stage))) else $error("copy"); // R9

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_rise |=> $stable(active)) else $error("hold"); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (active == '0)) else $error("rst"); // R1
endmodule

// File: rtl/param_shadow_loader.sv
// Module param_shadow_loader
// Top level: the byte decoder feeds the staging bank, and the frame commit
// copies the staging bank into the active parameter output on vsync rises.
// Assumes all inputs are synchronous to clk.
module param_shadow_loader
    import psl_pkg::*;
#(
    parameter int unsigned SLOT_N = 7,
    localparam int unsigned IDX_W = (SLOT_N > 1) ? $clog2(SLOT_N) : 1,
    localparam int unsigned REG_W = SLOT_N * SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              byte_vld,
    input  logic              vsync,
    output logic [REG_W-1:0]  params_active
);
    logic              wr_en;
    logic [IDX_W-1:0]  wr_slot;
    logic [SLOT_W-1:0] wr_data;
    logic [REG_W-1:0]  stage;

    psl_tag_decoder #(.SLOT_N(SLOT_N)) i_decoder (
        .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .byte_vld(byte_vld),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data)
    );

    psl_stage_bank #(.SLOT_N(SLOT_N)) i_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_data(wr_data), .stage(stage)
    );

    psl_frame_commit #(.REG_W(REG_W)) i_commit (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .stage(stage),
        .active(params_active)
    );

    AST_NO_BYTE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |-> !wr_en) else $error("vld"); // R7

    AST_ADDR_BYTE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_in[TAG_BIT]) |=> $stable(stage)) else $error("tag"); // R2
endmodule

// File: tb/test_param_shadow_loader.sv
`timescale 1ns/1ps
module test_param_shadow_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        byte_vld = 1'b0;
    logic        vsync = 1'b0;
    logic [48:0] params_active;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    param_shadow_loader i_param_shadow_loader (
        .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .byte_vld(byte_vld),
        .vsync(vsync), .params_active(params_active)
    );

    typedef struct packed {
        logic [7:0]  b;
        logic        v;
        logic        vs;
        logic [3:0]  req;
        logic [48:0] exp;
    } vec_t;

    localparam logic [48:0] A1 = 49'h2A | (49'h7F << 21);
    localparam logic [48:0] A2 = A1 | (49'h01 << 42);

    localparam vec_t TBL [16] = '{
        '{8'h15, 1'b1, 1'b0, 4'd4, 49'h0}, // R4 data before any address
        '{8'h00, 1'b0, 1'b1, 4'd4, 49'h0}, // R4 commit shows nothing staged
        '{8'h80, 1'b1, 1'b0, 4'd2, 49'h0}, // R2 select slot 0
        '{8'h2A, 1'b1, 1'b0, 4'd8, 49'h0}, // R8 staged, not yet active
        '{8'h83, 1'b1, 1'b0, 4'd2, 49'h0}, // R2 select slot 3
        '{8'h7F, 1'b1, 1'b0, 4'd3, 49'h0}, // R3 slot 3 staged
        '{8'h11, 1'b0, 1'b0, 4'd7, 49'h0}, // R7 byte without strobe
        '{8'h00, 1'b0, 1'b1, 4'd3, A1},    // R3 commit slots 0 and 3
        '{8'h86, 1'b1, 1'b1, 4'd8, A1},    // R8 vsync held high
        '{8'h55, 1'b1, 1'b1, 4'd8, A1},    // R8 no recommit on level
        '{8'h01, 1'b1, 1'b1, 4'd6, A1},    // R6 overwrite slot 6
        '{8'h00, 1'b0, 1'b0, 4'd8, A1},    // R8 vsync falls
        '{8'h00, 1'b0, 1'b1, 4'd6, A2},    // R6 slot 6 holds last value
        '{8'h87, 1'b1, 1'b0, 4'd5, A2},    // R5 out of range address
        '{8'h33, 1'b1, 1'b0, 4'd5, A2},    // R5 data goes nowhere
        '{8'h00, 1'b0, 1'b1, 4'd5, A2}     // R5 commit unchanged
    };

    task automatic step(input logic [7:0] b, input logic v, input logic vs);
        @(negedge clk);
        byte_in = b; byte_vld = v; vsync = vs;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic [48:0] exp, input string tag);
        n_cmp++;
        if (params_active !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, params_active, exp);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) step(8'h00, 1'b0, 1'b0);
        check(49'h0, "R1 reset");
        @(negedge clk) rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < 16; i++) begin
            step(TBL[i].b, TBL[i].v, TBL[i].vs);
            n_cmp++;
            if (params_active !== TBL[i].exp) begin
                n_bad++;
                $display("FAIL table[%0d] R%0d: actual %h expected %h",
                         i, TBL[i].req, params_active, TBL[i].exp);
            end
        end

        // R9: write on the commit edge goes to the next frame
        step(8'h00, 1'b0, 1'b0);
        step(8'h82, 1'b1, 1'b0);
        step(8'h0F, 1'b1, 1'b1);
        check(A2, "R9 same-edge commit");
        step(8'h00, 1'b0, 1'b0);
        step(8'h00, 1'b0, 1'b1);
        check(A2 | (49'h0F << 14), "R9 next commit");

        // R3: slot 1 boundary bits 13..7
        step(8'h81, 1'b1, 1'b0);
        step(8'h7F, 1'b1, 1'b0);
        step(8'h00, 1'b0, 1'b1);
        check(A2 | (49'h0F << 14) | (49'h7F << 7), "R3 slot 1 field");

        // R1: reset mid-stream clears all state
        step(8'h84, 1'b1, 1'b0);
        step(8'h44, 1'b1, 1'b0);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk) #1;
        check(49'h0, "R1 reset clears active");
        @(negedge clk) rst_n = 1'b1;
        step(8'h22, 1'b1, 1'b0);
        step(8'h00, 1'b0, 1'b1);
        check(49'h0, "R1 staging and address flag cleared");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule